// File: doc/BRIEF.md
# Predicated Execute and Flag-Update Stage

This block sits at the execute stage of a small 32-bit load/store core. Each cycle it may accept one instruction, qualified by a valid bit. It tests the instruction's 4-bit condition field against the N, Z, C and V flags held in its status word, and from that it decides whether the instruction commits. The ALU result, a flag-update request, and the ALU's carry and overflow bits all arrive as inputs. The block gates register writeback and the flag update on the outcome of the condition test, and it only lets a fault through when the instruction actually executes.

In the same cycle it also builds the immediate operand. This is an 8-bit constant rotated right by twice a 4-bit rotate field, and the rotation also produces a shifter carry. All outputs are registered and appear one clock after the instruction is accepted. A flag update is therefore seen by the instruction that directly follows.

Top module: `pred_exec_stage`

## Requirements
- R1: The single-flag conditions decode as follows: code 0 passes when Z=1, code 1 when Z=0, code 2 when C=1, code 3 when C=0, code 4 when N=1, code 5 when N=0, code 6 when V=1 and code 7 when V=0.
- R2: The compare conditions decode as follows: code 8 passes when C=1 and Z=0, code 9 when C=0 or Z=1, code 10 when N==V, code 11 when N!=V, code 12 when Z=0 and N==V, and code 13 when Z=1 or N!=V.
- R3: Code 14 always passes and code 15 never passes.
- R4: A valid instruction whose condition passes and that has no fault raises `commit_o` for exactly one cycle, on the clock edge that follows its acceptance. `wb_en_o` is raised only together with `commit_o`, and only when `in_wr_en` is set. `wb_data_o` is the captured `alu_result`.
- R5: A valid instruction whose condition fails raises none of `commit_o`, `wb_en_o` or `fault_o`, and it leaves `status_o` unchanged, even when `in_fault` and `in_set_flags` are set.
- R6: A passing instruction that has `in_fault` set raises `fault_o` instead of `commit_o`. It does not write back and does not change the flags.
- R7: A committed instruction with `in_set_flags` set writes N=`alu_result[31]` to bit 31, Z=(`alu_result`==0) to bit 30, C=`alu_carry` to bit 29 and V=`alu_ovf` to bit 28 of `status_o`. Bits 27..0 are never changed and stay zero.
- R8: `imm_o` is `in_imm8`, zero-extended and rotated right by 2*`in_rot` bit positions, taken modulo 32.
- R9: `imm_carry_o` is bit 31 of the rotated immediate when `in_rot` is nonzero. When `in_rot` is zero it is the C flag as it stood before the instruction.
- R10: The condition is evaluated against the flags registered before the instruction, so an update made by one instruction steers the instruction that directly follows it.
- R11: A synchronous active-high reset clears `status_o` and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_cond | input | 4 | Condition field |
| in_imm8 | input | 8 | Immediate constant |
| in_rot | input | 4 | Rotate field (amount is twice this) |
| in_set_flags | input | 1 | Instruction requests a flag update |
| in_wr_en | input | 1 | Instruction has a destination register |
| in_fault | input | 1 | Fault signalled during execution |
| alu_result | input | 32 | ALU result |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU overflow |
| commit_o | output | 1 | Instruction committed |
| wb_en_o | output | 1 | Register writeback strobe |
| wb_data_o | output | 32 | Writeback data |
| fault_o | output | 1 | Fault from an executed instruction |
| imm_o | output | 32 | Rotated immediate |
| imm_carry_o | output | 1 | Shifter carry |
| status_o | output | 32 | Status word, flags in bits 31..28 |

## Verification
The bench steps through every reachable flag combination. After each one it tests all sixteen codes in the very next cycle. A decoder with a swapped or inverted equation would commit on the wrong flags, and a stage that evaluated against stale or freshly computed flags would fail the back-to-back ordering. Faulting and failing instructions are sent with flag updates requested, so a gate placed in the wrong spot shows up as a changed status word or a stray `fault_o`. The bench sweeps all rotate values, including zero. A rotator that took the amount without doubling it, or that drove the carry from the rotated bit when the rotate is zero, would produce the wrong operand or carry.

// File: rtl/pexe_pkg.sv
package pexe_pkg;
  typedef enum logic [3:0] {
    CC_ZSET = 4'd0, CC_ZCLR, CC_CSET, CC_CCLR, CC_NSET, CC_NCLR,
    CC_VSET, CC_VCLR, CC_UGT, CC_ULE, CC_SGE, CC_SLT, CC_SGT, CC_SLE,
    CC_ALWAYS, CC_NEVER
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/pexe_cond_eval.sv
module pexe_cond_eval
  import pexe_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     fl,
  output logic       pass
);
  cond_e code;
  assign code = cond_e'(cond);

  always_comb begin
    unique case (code)
      CC_ZSET:   pass = fl.z;
      CC_ZCLR:   pass = ~fl.z;
      CC_CSET:   pass = fl.c;
      CC_CCLR:   pass = ~fl.c;
      CC_NSET:   pass = fl.n;
      CC_NCLR:   pass = ~fl.n;
      CC_VSET:   pass = fl.v;
      CC_VCLR:   pass = ~fl.v;
      CC_UGT:    pass = fl.c & ~fl.z;
      CC_ULE:    pass = ~fl.c | fl.z;
      CC_SGE:    pass = ~(fl.n ^ fl.v);
      CC_SLT:    pass = fl.n ^ fl.v;
      CC_SGT:    pass = ~fl.z & ~(fl.n ^ fl.v);
      CC_SLE:    pass = fl.z | (fl.n ^ fl.v);
      CC_ALWAYS: pass = 1'b1;
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/pexe_imm_rotator.sv
module pexe_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              c_in,
  output logic [DATA_W-1:0] value,
  output logic              carry
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   ext;
  logic [AMT_W-1:0]    amt;
  logic [2*DATA_W-1:0] dbl;

  assign ext = DATA_W'(imm);

  always_comb begin
    int a;
    a   = (int'(rot) * 2) % DATA_W;
    amt = AMT_W'(a);
  end

  assign dbl   = {ext, ext} >> amt;
  assign value = dbl[DATA_W-1:0];
  assign carry = (amt != '0) ? value[DATA_W-1] : c_in;
endmodule

// File: rtl/pexe_flag_next.sv
module pexe_flag_next
  import pexe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              ovf,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] status_next
);
  flags_t nf;

  assign nf.n = result[DATA_W-1];
  assign nf.z = (result == '0);
  assign nf.c = carry;
  assign nf.v = ovf;

  assign status_next = {nf, status[DATA_W-5:0]};
endmodule

// File: rtl/pred_exec_stage.sv
module pred_exec_stage
  import pexe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [COND_W-1:0] in_cond,
  input  logic [IMM_W-1:0]  in_imm8,
  input  logic [ROT_W-1:0]  in_rot,
  input  logic              in_set_flags,
  input  logic              in_wr_en,
  input  logic              in_fault,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  output logic              commit_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] imm_o,
  output logic              imm_carry_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int FLAG_HI = DATA_W - 1;
  localparam int FLAG_LO = DATA_W - 4;

  logic [DATA_W-1:0] status_q, status_nx;
  flags_t            cur_fl;
  logic              pass, exec_ok;
  logic [DATA_W-1:0] imm_val;
  logic              imm_cy;

  assign cur_fl = flags_t'(status_q[FLAG_HI:FLAG_LO]);

  pexe_cond_eval u_cond (
    .cond (in_cond),
    .fl   (cur_fl),
    .pass (pass)
  );

  pexe_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm   (in_imm8),
    .rot   (in_rot),
    .c_in  (cur_fl.c),
    .value (imm_val),
    .carry (imm_cy)
  );

  pexe_flag_next #(.DATA_W(DATA_W)) u_fn (
    .result      (alu_result),
    .carry       (alu_carry),
    .ovf         (alu_ovf),
    .status      (status_q),
    .status_next (status_nx)
  );

  assign exec_ok = in_valid & pass & ~in_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q    <= '0;
      commit_o    <= 1'b0;
      wb_en_o     <= 1'b0;
      fault_o     <= 1'b0;
      wb_data_o   <= '0;
      imm_o       <= '0;
      imm_carry_o <= 1'b0;
    end else begin
      commit_o <= exec_ok;
      wb_en_o  <= exec_ok & in_wr_en;
      fault_o  <= in_valid & pass & in_fault;
      if (in_valid) begin
        wb_data_o   <= alu_result;
        imm_o       <= imm_val;
        imm_carry_o <= imm_cy;
      end
      if (exec_ok && in_set_flags)
        status_q <= status_nx;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/pred_exec_stage_chk.sv
module pred_exec_stage_chk #(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 4,
  parameter int COND_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [COND_W-1:0] in_cond,
  input logic [ROT_W-1:0]  in_rot,
  input logic              in_fault,
  input logic              commit_o,
  input logic              wb_en_o,
  input logic              fault_o,
  input logic              imm_carry_o,
  input logic [DATA_W-1:0] status_o
);
  localparam int C_BIT = DATA_W - 3;

  assert_commit_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(in_valid));
  assert_wb_only_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> commit_o);
  assert_never_code_R3: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($past(in_cond) != COND_W'(15)));
  assert_always_code_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cond == COND_W'(14) && !in_fault) |=> commit_o);
  assert_flags_need_commit_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_o) |-> commit_o);
  assert_fault_excludes_commit_R6: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && fault_o));
  assert_low_status_zero_R7: assert property (@(posedge clk) disable iff (rst)
    status_o[DATA_W-5:0] == '0);
  assert_carry_rot0_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rot == '0) |=> (imm_carry_o == $past(status_o[C_BIT])));
endmodule

bind pred_exec_stage pred_exec_stage_chk #(.DATA_W(DATA_W), .ROT_W(ROT_W), .COND_W(COND_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_cond(in_cond), .in_rot(in_rot),
  .in_fault(in_fault), .commit_o(commit_o), .wb_en_o(wb_en_o), .fault_o(fault_o),
  .imm_carry_o(imm_carry_o), .status_o(status_o)
);

// File: tb/sim_pred_exec_stage.sv
module sim_pred_exec_stage;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_set_flags, in_wr_en, in_fault, alu_carry, alu_ovf;
  logic [3:0]  in_cond, in_rot;
  logic [7:0]  in_imm8;
  logic [31:0] alu_result;
  logic        commit_o, wb_en_o, fault_o, imm_carry_o;
  logic [31:0] wb_data_o, imm_o, status_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mstat;

  always #4 clk = ~clk;

  pred_exec_stage u0 (.*);

  function automatic bit ref_pass(input logic [3:0] c, input logic [31:0] s);
    bit n, z, cy, v, base;
    n = s[31]; z = s[30]; cy = s[29]; v = s[28];
    if (c == 4'd14) return 1'b1;
    if (c == 4'd15) return 1'b0;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy && !z;
      3'd5: base = (n == v);
      default: base = !z && (n == v);
    endcase
    return c[0] ? !base : base;
  endfunction

  function automatic logic [31:0] ref_rot(input logic [7:0] im, input logic [3:0] r);
    logic [31:0] e, o;
    int a;
    e = {24'd0, im};
    a = (r * 2) % 32;
    for (int i = 0; i < 32; i++) o[i] = e[(i + a) % 32];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [7:0] im, input logic [3:0] r,
                       input bit sf, input bit we, input bit fl,
                       input logic [31:0] res, input bit cy, input bit ov, input string note);
    bit p;
    logic [31:0] ei, ns;
    bit ec;
    string ctag;
    in_valid = 1'b1; in_cond = c; in_imm8 = im; in_rot = r;
    in_set_flags = sf; in_wr_en = we; in_fault = fl;
    alu_result = res; alu_carry = cy; alu_ovf = ov;
    p  = ref_pass(c, mstat);
    ei = ref_rot(im, r);
    ec = (r != 0) ? ei[31] : mstat[29];
    ns = mstat;
    if (p && !fl && sf) ns = {res[31], res == 32'd0, cy, ov, mstat[27:0]};
    ctag = (c < 8) ? "R1" : (c < 14) ? "R2" : "R3";
    @(posedge clk);
    @(negedge clk);
    chk({ctag, note}, {31'd0, commit_o | fault_o}, {31'd0, p});
    chk(!p ? "R5 commit" : fl ? "R6 commit" : "R4 commit", {31'd0, commit_o}, {31'd0, p && !fl});
    chk(!p ? "R5 wb_en" : "R4 wb_en", {31'd0, wb_en_o}, {31'd0, p && !fl && we});
    chk(!p ? "R5 fault" : "R6 fault", {31'd0, fault_o}, {31'd0, p && fl});
    chk("R4 wb_data", wb_data_o, res);
    chk("R7 status", status_o, ns);
    chk("R8 imm", imm_o, ei);
    chk("R9 carry", {31'd0, imm_carry_o}, {31'd0, ec});
    mstat = ns;
  endtask

  // Set flags through an always-passing, flag-updating instruction
  task automatic set_flags(input bit n, input bit z, input bit cy, input bit v);
    logic [31:0] res;
    res = z ? 32'd0 : (n ? 32'h8000_0001 : 32'h0000_0010);
    issue(4'd14, 8'h01, 4'd0, 1'b1, 1'b0, 1'b0, res, cy, v, " set");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 0; in_cond = 0; in_imm8 = 0; in_rot = 0;
    in_set_flags = 0; in_wr_en = 0; in_fault = 0; alu_result = 0;
    alu_carry = 0; alu_ovf = 0; mstat = 32'd0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 status", status_o, 32'd0);
    chk("R11 outputs", {commit_o, wb_en_o, fault_o, imm_carry_o}, 4'd0);
    chk("R11 imm", imm_o, 32'd0);
    rst = 1'b0;

    // R1 R2 R3 R10: every reachable flag set, then each code in the next cycle
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      for (int c = 0; c < 16; c++) begin
        set_flags(f[3], f[2], f[1], f[0]);
        issue(4'(c), 8'h3C, 4'd1, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 1'b0, 1'b0, " R10 next-cycle");
      end
    end

    // R5: failing code with flag update and fault requested
    set_flags(1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'd0, 8'h11, 4'd2, 1'b1, 1'b1, 1'b1, 32'd0, 1'b1, 1'b1, " R5 squash");
    issue(4'd15, 8'h11, 4'd2, 1'b1, 1'b1, 1'b0, 32'd0, 1'b1, 1'b1, " R5 never");
    // R6: passing with fault, flag update blocked
    issue(4'd14, 8'h22, 4'd3, 1'b1, 1'b1, 1'b1, 32'h8000_0000, 1'b1, 1'b1, " R6 fault");
    // R7: each flag source
    issue(4'd14, 8'h00, 4'd0, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 1'b1, " R7 nv");
    issue(4'd14, 8'h00, 4'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, " R7 zc");

    // R8 R9: every rotate value, carry from rotated bit or current C
    for (int r = 0; r < 16; r++) begin
      issue(4'd14, 8'hA5, 4'(r), 1'b0, 1'b1, 1'b0, 32'd7, 1'b0, 1'b0, " R8 sweep");
      issue(4'd14, 8'h80, 4'(r), 1'b0, 1'b1, 1'b0, 32'd9, 1'b0, 1'b0, " R9 sweep");
    end
    set_flags(1'b0, 1'b0, 1'b1, 1'b0);
    issue(4'd14, 8'hFF, 4'd0, 1'b0, 1'b0, 1'b0, 32'd1, 1'b0, 1'b0, " R9 rot0 C=1");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rr;
      rr = $urandom;
      if (($urandom % 8) == 0) rr = 32'd0;
      if (($urandom % 5) == 0) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R4 idle commit", {31'd0, commit_o | wb_en_o | fault_o}, 32'd0);
        chk("R5 idle status", status_o, mstat);
      end
      issue(4'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
            (($urandom % 6) == 0), rr, 1'($urandom), 1'($urandom), " random");
    end
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R4 drain", {31'd0, commit_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule